// File: doc/BRIEF.md
# Serial Configuration Register Interface for a Frequency Synthesizer

This block receives 21-bit command words over a three-wire serial link (data, shift clock, latch) and keeps the divider and lock-acceleration settings of a frequency synthesizer. All three serial lines are sampled in the system clock domain. Each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. A rising edge of the latch line decodes the word held at that moment. The two bits shifted in last form the command code. The code selects one of four actions: a reference-divider write together with the acceleration options, a feedback-divider write together with the acceleration start/stop flag, a load of fixed defaults, or a write of the diagnostic selector bits.

The divider values are not handed straight to the counters. A decoded word updates a staged copy. The staged copy moves to the applied outputs only on a comparison-cycle boundary pulse, so that a counter never reloads from a half-written value. The acceleration flags take effect as soon as the word is decoded. While the standby input is high the counters are held clear, so the applied values follow the staged ones on every cycle. Standby never erases a stored setting. The diagnostic selector bits are honoured only while the test-disable input is low. While that input is high they read as zero.

Top module: `pll_serial_cfg`

## Requirements
- R1: A word takes effect only on a rising edge of `ser_latch`. Shifting bits with `ser_latch` low leaves every output unchanged. Bits enter most significant first, so after 21 shift-clock rises the bit shifted last sits at word bit 0.
- R2: When word bits [1:0] are 00, the word is a reference write. Bits [16:2] become the staged reference divider, with the least significant bit at word bit 2. Bit 17 sets `sat_rst`, bit 19 sets `cp_dbl` and bit 20 sets `auto_end`. Bit 18 is reserved and has no effect.
- R3: When word bit 0 is 1 and bit 1 is 0, the word is a feedback write. Bits [6:2] become the staged swallow value and bits [19:7] the staged main value. Bit 20 sets `pull_go`. The reference divider and the other flags are untouched.
- R4: When word bits [1:0] are 11, the staged values load the defaults: reference 40, swallow 3, main 181 (a feedback ratio of 5795), with all four acceleration flags at 1. Reset loads the same values into both the staged and the applied registers, and clears `test_sel`.
- R5: When word bit 0 is 0 and bit 1 is 1, the word is a diagnostic write. Word bits [5:2] become `test_sel[3:0]` if `test_off` is low.
- R6: While `test_off` is high, `test_sel` reads zero from the first clock edge after `test_off` rises. A diagnostic write made during that time is dropped, and it does not appear once `test_off` falls.
- R7: The applied divider outputs change only on the clock edge that samples `cmp_tick` high. They then take the staged values, so a decoded word does not reach them before a tick. The acceleration flags update on the edge that sees the latch rise.
- R8: While `standby` is high, the applied divider outputs copy the staged values on every clock edge. Leaving standby keeps all stored divider and flag values.
- R9: If fewer than 21 bits are shifted before the latch, the word is decoded from the shift register as it stands. That word is the previous contents moved left by the number of new bits, with the new bits at the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, rising edge shifts |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Latch enable, rising edge decodes the word |
| test_off | input | 1 | High disables the diagnostic selector |
| standby | input | 1 | High: counters held clear, settings retained |
| cmp_tick | input | 1 | One-cycle pulse at a comparison-cycle boundary |
| ref_div | output | 15 | Applied reference divider |
| swallow | output | 5 | Applied swallow value |
| main_div | output | 13 | Applied main divider |
| pull_go | output | 1 | Lock-acceleration active flag |
| sat_rst | output | 1 | Loop-filter saturation reset option |
| cp_dbl | output | 1 | Doubled charge-current option |
| auto_end | output | 1 | End acceleration automatically on lock |
| test_sel | output | 4 | Diagnostic selector bits |

## Verification
The assertions assume that the serial lines are already synchronous to `clk`, that each level is held for at least one clock so every edge is seen, and that `ser_latch` does not rise on the same cycle as a shift-clock rise. The bench changes every input on the falling edge of `clk`, holds each serial level for a whole clock, and lowers the shift clock before it raises the latch. The bench gives `cmp_tick` as an isolated one-cycle pulse. It lowers `standby` only after the staged values are settled.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
    localparam int WORD_W = 21;
    localparam int REF_W  = 15;
    localparam int SWL_W  = 5;
    localparam int MAIN_W = 13;
    localparam int TSEL_W = 4;

    // field positions inside the received word (bit 0 is the last bit shifted)
    localparam int FLD_LO   = 2;
    localparam int REF_HI   = FLD_LO + REF_W - 1;
    localparam int SAT_BIT  = REF_HI + 1;
    localparam int RSV_BIT  = REF_HI + 2;
    localparam int CPD_BIT  = REF_HI + 3;
    localparam int AEND_BIT = REF_HI + 4;
    localparam int SWL_HI   = FLD_LO + SWL_W - 1;
    localparam int MAIN_HI  = SWL_HI + MAIN_W;
    localparam int GO_BIT   = MAIN_HI + 1;
    localparam int TSEL_HI  = FLD_LO + TSEL_W - 1;

    localparam logic [REF_W-1:0]  DEF_REF  = REF_W'(40);
    localparam logic [SWL_W-1:0]  DEF_SWL  = SWL_W'(3);
    localparam logic [MAIN_W-1:0] DEF_MAIN = MAIN_W'(181);

    typedef enum logic [1:0] {
        CMD_REF  = 2'b00,
        CMD_FB   = 2'b10,
        CMD_INIT = 2'b11,
        CMD_TEST = 2'b01
    } cmd_e;

    typedef struct packed {
        logic [REF_W-1:0]  ref_v;
        logic [SWL_W-1:0]  swl_v;
        logic [MAIN_W-1:0] main_v;
    } div_t;

    typedef struct packed {
        logic go;
        logic sat;
        logic cpd;
        logic aend;
    } accel_t;

    localparam div_t   DEF_DIV   = '{ref_v: DEF_REF, swl_v: DEF_SWL, main_v: DEF_MAIN};
    localparam accel_t DEF_ACCEL = '{go: 1'b1, sat: 1'b1, cpd: 1'b1, aend: 1'b1};

    // code is {first-arriving-last bit, second-to-last bit} = {word[0], word[1]}
    function automatic cmd_e word_cmd(input logic [WORD_W-1:0] w);
        return cmd_e'({w[0], w[1]});
    endfunction
endpackage

// File: rtl/pcfg_serial_rx.sv
module pcfg_serial_rx
    import pll_cfg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_dat,
    input  logic         ser_latch,
    output logic [W-1:0] word,
    output logic         load
);
    logic ck_q, le_q;
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q <= 1'b0;
            le_q <= 1'b0;
            sr   <= '0;
        end else begin
            ck_q <= ser_clk;
            le_q <= ser_latch;
            if (ser_clk && !ck_q)
                sr <= {sr[W-2:0], ser_dat};
        end
    end

    assign word = sr;
    assign load = ser_latch && !le_q;
endmodule

// File: rtl/pcfg_cmd_regs.sv
module pcfg_cmd_regs
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              test_off,
    output div_t              stg,
    output accel_t            accel,
    output logic [TSEL_W-1:0] tsel
);
    logic unused_rsv;
    assign unused_rsv = word[RSV_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg   <= DEF_DIV;
            accel <= DEF_ACCEL;
            tsel  <= '0;
        end else begin
            if (load) begin
                unique case (word_cmd(word))
                    CMD_REF: begin
                        stg.ref_v  <= word[REF_HI:FLD_LO];
                        accel.sat  <= word[SAT_BIT];
                        accel.cpd  <= word[CPD_BIT];
                        accel.aend <= word[AEND_BIT];
                    end
                    CMD_FB: begin
                        stg.swl_v  <= word[SWL_HI:FLD_LO];
                        stg.main_v <= word[MAIN_HI:SWL_HI+1];
                        accel.go   <= word[GO_BIT];
                    end
                    CMD_INIT: begin
                        stg   <= DEF_DIV;
                        accel <= DEF_ACCEL;
                    end
                    CMD_TEST: begin
                        if (!test_off)
                            tsel <= word[TSEL_HI:FLD_LO];
                    end
                    default: ;
                endcase
            end
            if (test_off)
                tsel <= '0;
        end
    end
endmodule

// File: rtl/pcfg_div_xfer.sv
module pcfg_div_xfer
    import pll_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmp_tick,
    input  logic standby,
    input  div_t stg,
    output div_t act
);
    always_ff @(posedge clk) begin
        if (rst)
            act <= DEF_DIV;
        else if (cmp_tick || standby)
            act <= stg;
    end
endmodule

// File: rtl/pll_serial_cfg.sv
module pll_serial_cfg
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_latch,
    input  logic              test_off,
    input  logic              standby,
    input  logic              cmp_tick,
    output logic [REF_W-1:0]  ref_div,
    output logic [SWL_W-1:0]  swallow,
    output logic [MAIN_W-1:0] main_div,
    output logic              pull_go,
    output logic              sat_rst,
    output logic              cp_dbl,
    output logic              auto_end,
    output logic [TSEL_W-1:0] test_sel
);
    logic [WORD_W-1:0] word;
    logic              load;
    div_t              stg_div;
    div_t              act_div;
    accel_t            accel;

    pcfg_serial_rx #(.W(WORD_W)) u_rx (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .word(word), .load(load)
    );

    pcfg_cmd_regs u_regs (
        .clk(clk), .rst(rst), .load(load), .word(word), .test_off(test_off),
        .stg(stg_div), .accel(accel), .tsel(test_sel)
    );

    pcfg_div_xfer u_xfer (
        .clk(clk), .rst(rst), .cmp_tick(cmp_tick), .standby(standby),
        .stg(stg_div), .act(act_div)
    );

    assign ref_div  = act_div.ref_v;
    assign swallow  = act_div.swl_v;
    assign main_div = act_div.main_v;
    assign pull_go  = accel.go;
    assign sat_rst  = accel.sat;
    assign cp_dbl   = accel.cpd;
    assign auto_end = accel.aend;
endmodule

// File: rtl/pll_serial_cfg_chk.sv
module pll_serial_cfg_chk
    import pll_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ser_latch,
    input logic              test_off,
    input logic              standby,
    input logic              cmp_tick,
    input logic [REF_W-1:0]  ref_div,
    input logic [SWL_W-1:0]  swallow,
    input logic [MAIN_W-1:0] main_div,
    input logic              pull_go,
    input logic              sat_rst,
    input logic              cp_dbl,
    input logic              auto_end,
    input logic [TSEL_W-1:0] test_sel,
    input div_t              stg_div
);
    // R1: without the latch line high, no flag can move
    a_r1_no_latch_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !ser_latch |=> $stable({pull_go, sat_rst, cp_dbl, auto_end}));

    // R5: diagnostic bits move only through a latch or test_off
    a_r5_tsel_hold: assert property (@(posedge clk) disable iff (rst)
        (!ser_latch && !test_off) |=> $stable(test_sel));

    // R6: test disabled forces the selector to zero
    a_r6_tsel_zero: assert property (@(posedge clk) disable iff (rst)
        test_off |=> (test_sel == '0));

    // R7: applied dividers are frozen between boundary pulses
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!cmp_tick && !standby) |=> $stable({ref_div, swallow, main_div}));

    // R7: a boundary pulse hands over the staged values
    a_r7_tick_transfer: assert property (@(posedge clk) disable iff (rst)
        cmp_tick |=> ({ref_div, swallow, main_div} == $past(stg_div)));

    // R8: in standby the applied values track the staged ones
    a_r8_standby_track: assert property (@(posedge clk) disable iff (rst)
        standby |=> ({ref_div, swallow, main_div} == $past(stg_div)));
endmodule

bind pll_serial_cfg pll_serial_cfg_chk u_chk (
    .clk(clk), .rst(rst), .ser_latch(ser_latch), .test_off(test_off),
    .standby(standby), .cmp_tick(cmp_tick), .ref_div(ref_div),
    .swallow(swallow), .main_div(main_div), .pull_go(pull_go),
    .sat_rst(sat_rst), .cp_dbl(cp_dbl), .auto_end(auto_end),
    .test_sel(test_sel), .stg_div(stg_div)
);

// File: tb/pll_serial_cfg_tb.sv
module pll_serial_cfg_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
    logic test_off = 1'b1, standby = 1'b0, cmp_tick = 1'b0;
    logic [14:0] ref_div;
    logic [4:0]  swallow;
    logic [12:0] main_div;
    logic        pull_go, sat_rst, cp_dbl, auto_end;
    logic [3:0]  test_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_serial_cfg u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .test_off(test_off), .standby(standby),
        .cmp_tick(cmp_tick), .ref_div(ref_div), .swallow(swallow),
        .main_div(main_div), .pull_go(pull_go), .sat_rst(sat_rst),
        .cp_dbl(cp_dbl), .auto_end(auto_end), .test_sel(test_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // word builders: bit 0 = last bit shifted in
    function automatic logic [20:0] w_ref(input logic [14:0] r, input logic s,
                                          input logic rsv, input logic i, input logic e);
        return {e, i, rsv, s, r, 2'b00};
    endfunction
    function automatic logic [20:0] w_fb(input logic [12:0] m, input logic [4:0] s,
                                         input logic f);
        return {f, m, s, 2'b01};
    endfunction
    function automatic logic [20:0] w_test(input logic [3:0] t);
        return {15'd0, t, 2'b10};
    endfunction

    task automatic shift_bits(input logic [20:0] w, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            @(negedge clk); ser_dat = w[k];
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic latch();
        @(negedge clk); ser_latch = 1'b1;
        @(negedge clk); ser_latch = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [20:0] w);
        shift_bits(w, 21);
        latch();
    endtask

    task automatic tick();
        @(negedge clk); cmp_tick = 1'b1;
        @(negedge clk); cmp_tick = 1'b0;
    endtask

    task automatic chk_div(input string req, input int r, input int s, input int m);
        chk({req, " ref_div"}, int'(ref_div), r);
        chk({req, " swallow"}, int'(swallow), s);
        chk({req, " main_div"}, int'(main_div), m);
    endtask

    task automatic chk_flags(input string req, input logic [3:0] gsie);
        chk({req, " flags go/sat/cpd/aend"}, int'({pull_go, sat_rst, cp_dbl, auto_end}), int'(gsie));
    endtask

    task automatic t_reset();
        chk_div("R4 reset", 40, 3, 181);
        chk_flags("R4 reset", 4'b1111);
        chk("R4 reset test_sel", int'(test_sel), 0);
    endtask

    task automatic t_ref_write();
        // reserved bit set to 1: must have no effect
        send(w_ref(15'd100, 1'b1, 1'b1, 1'b0, 1'b1));
        chk_flags("R2 ref write flags", 4'b1101);
        chk_div("R7 before tick", 40, 3, 181);
        tick();
        chk_div("R2 ref write applied", 100, 3, 181);
    endtask

    task automatic t_fb_write();
        send(w_fb(13'd78, 5'd4, 1'b0));
        chk_flags("R3 fb write flags", 4'b0101);
        tick();
        chk_div("R3 fb write applied", 100, 4, 78);
    endtask

    task automatic t_no_latch();
        shift_bits(w_fb(13'd8191, 5'd31, 1'b1), 21);
        repeat (3) @(negedge clk);
        tick();
        chk_div("R1 no latch", 100, 4, 78);
        chk_flags("R1 no latch", 4'b0101);
        latch();
        tick();
        chk_div("R1 latch after shift", 100, 31, 8191);
        chk_flags("R1 latch after shift", 4'b1101);
    endtask

    task automatic t_init();
        send({19'h5A5A5, 2'b11});
        chk_flags("R4 init flags", 4'b1111);
        tick();
        chk_div("R4 init applied", 40, 3, 181);
    endtask

    task automatic t_test_bits();
        @(negedge clk); test_off = 1'b0;
        send(w_test(4'b1010));
        chk("R5 test_sel written", int'(test_sel), 10);
        @(negedge clk); test_off = 1'b1;
        @(negedge clk);
        chk("R6 test_sel cleared", int'(test_sel), 0);
        send(w_test(4'b0101));
        chk("R6 write while disabled", int'(test_sel), 0);
        @(negedge clk); test_off = 1'b0;
        @(negedge clk);
        chk("R6 dropped write stays out", int'(test_sel), 0);
        @(negedge clk); test_off = 1'b1;
    endtask

    task automatic t_standby();
        @(negedge clk); standby = 1'b1;
        send(w_ref(15'd1234, 1'b0, 1'b0, 1'b1, 1'b0));
        chk_div("R8 standby tracks", 1234, 3, 181);
        @(negedge clk); standby = 1'b0;
        repeat (4) @(negedge clk);
        chk_div("R8 retained after standby", 1234, 3, 181);
        chk_flags("R8 flags retained", 4'b1010);
    endtask

    task automatic t_short_word();
        logic [20:0] w, w2;
        w = w_ref(15'd12345, 1'b1, 1'b1, 1'b0, 1'b0);
        send(w);
        tick();
        w2 = {w[18:0], 2'b01};
        shift_bits(2'b01, 2);
        latch();
        tick();
        chk("R9 short word swallow", int'(swallow), int'(w2[6:2]));
        chk("R9 short word main", int'(main_div), int'(w2[19:7]));
        chk("R9 short word go", int'(pull_go), int'(w2[20]));
        chk("R9 short word ref kept", int'(ref_div), 12345);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ref_write();
        t_fb_write();
        t_no_latch();
        t_init();
        t_test_bits();
        t_standby();
        t_short_word();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule